// File: doc/BRIEF.md
# Indexed Palette Store with Auto-Increment Pointer

This block holds the colour palettes of a display subsystem in two independent channels: channel 0 serves the background layer and channel 1 serves sprite objects. Each channel keeps 64 palette bytes. The CPU reaches them over a byte-wide register bus through a pair of registers per channel. A pointer register selects one byte. A data register reads or writes the byte that the pointer selects. When its auto-step flag is set, the pointer moves forward by one after every data write, so software can load a whole palette in one burst of writes.

The display controller drives a gate input. While that input is low the video pipeline owns the palette storage, and CPU data reads return all ones. A legacy-mode input turns the block off for software that predates colour palettes. In that mode register writes are dropped and data reads return all ones. A separate read port lets the video pipeline fetch any palette byte at any time. Each channel has a change strobe that reports data writes which actually altered a stored byte.

Top module: `palette_port`

## Requirements
- R1: `bus_addr[0]` selects the pointer register (0) or the data register (1), and `bus_addr[ADDR_W-1:1]` selects the channel: 0 is background and 1 is objects.
- R2: A pointer register read returns the auto-step flag in bit 7, a constant 1 in bit 6 and the 6-bit pointer in bits 5:0. Writing 0 to bit 6 does not change it.
- R3: A data write stores `bus_wdata` at the current pointer. If the auto-step flag is 1, the pointer then moves to pointer+1 modulo 64 and the flag keeps its value. If the flag is 0, the pointer stays where it is.
- R4: A data read returns the byte at the current pointer only when legacy mode is off and `pal_accessible` is high. Otherwise it returns 0xFF. A data read never moves the pointer.
- R5: While `legacy_mode` is high, writes to both the pointer register and the data register are ignored. Pointer register reads still return the stored value.
- R6: After reset, each pointer register reads 0xFF (flag 1, pointer 63), and every palette byte of both channels holds 0xFF.
- R7: `bus_rdata` is registered. It shows the result of a read in the cycle after `bus_rd` is sampled high, and it holds its value while `bus_rd` is low.
- R8: A data write that stores the value already held still advances the pointer when auto-step is on. `pal_changed[c]` is high for exactly the one cycle after a data write to channel c that altered the stored byte.
- R9: `vid_data` shows the byte at `vid_idx` of channel `vid_ch` one cycle after they are sampled. The video port does not depend on `pal_accessible` or `legacy_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| legacy_mode | input | 1 | High turns the block off (writes ignored, data reads 0xFF) |
| pal_accessible | input | 1 | High when the CPU may read palette bytes |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register select: {channel, data/pointer} |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| vid_ch | input | CH_W | Video port channel select |
| vid_idx | input | IDX_W | Video port palette index |
| vid_data | output | DATA_W | Video port palette byte |
| pal_changed | output | NUM_CH | Per-channel pulse after a data write that altered a byte |

## Verification
The bench writes to the last palette slot with auto-step on and expects the pointer to wrap to 0. A design that carries the wrap into bit 6 or bit 7 would read back a wrong pointer byte. It reads the data register several times in a row with auto-step set, which catches a design that also advances the pointer on reads. It rewrites a byte with its own value, expecting the pointer to move but no change pulse. It then writes a different value and expects a pulse on that channel only. Finally it tries writes in legacy mode and data reads with the gate low. A design that leaks either of these would return stored bytes where 0xFF is due, or would show a pointer that the write should not have reached.

// File: rtl/palette_pkg.sv
package palette_pkg;
   // register select bit 0: pointer or data register
   typedef enum logic {
      REG_POINTER = 1'b0,
      REG_DATA    = 1'b1
   } reg_kind_e;

   localparam int BG_CHANNEL  = 0;
   localparam int OBJ_CHANNEL = 1;
endpackage

// File: rtl/palette_decode.sv
module palette_decode
   import palette_pkg::*;
#(
   parameter int NUM_CH = 2,
   localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
   localparam int ADDR_W = CH_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   output logic [NUM_CH-1:0] ptr_wr,
   output logic [NUM_CH-1:0] dat_wr
);
   logic [CH_W-1:0] ch;
   reg_kind_e       kind;

   assign ch   = addr[ADDR_W-1:1];
   assign kind = reg_kind_e'(addr[0]);

   for (genvar c = 0; c < NUM_CH; c++) begin : g_sel
      assign ptr_wr[c] = enable && wr && (ch == CH_W'(c)) && (kind == REG_POINTER);
      assign dat_wr[c] = enable && wr && (ch == CH_W'(c)) && (kind == REG_DATA);
   end

   // R1: at most one register strobe per bus write
   assert_one_target_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ptr_wr, dat_wr}));
endmodule

// File: rtl/palette_channel.sv
module palette_channel #(
   parameter int DATA_W = 8,
   parameter int IDX_W  = 6,
   localparam int DEPTH  = 1 << IDX_W,
   localparam int FILL_W = DATA_W - IDX_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ptr_wr,
   input  logic              dat_wr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] ptr_byte,
   output logic [DATA_W-1:0] dat_byte,
   input  logic [IDX_W-1:0]  vid_idx,
   output logic [DATA_W-1:0] vid_byte,
   output logic              changed
);
   logic [DATA_W-1:0] ram [DEPTH];
   logic              step_q;
   logic [IDX_W-1:0]  ptr_q;
   logic              chg_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         step_q <= 1'b1;
         ptr_q  <= '1;
         chg_q  <= 1'b0;
         for (int i = 0; i < DEPTH; i++) ram[i] <= '1;
      end else begin
         chg_q <= 1'b0;
         if (ptr_wr) begin
            step_q <= wdata[DATA_W-1];
            ptr_q  <= wdata[IDX_W-1:0];
         end else if (dat_wr) begin
            ram[ptr_q] <= wdata;
            chg_q      <= (ram[ptr_q] != wdata);
            if (step_q) ptr_q <= ptr_q + IDX_W'(1);
         end
      end
   end

   assign ptr_byte = {step_q, {FILL_W{1'b1}}, ptr_q};
   assign dat_byte = ram[ptr_q];
   assign vid_byte = ram[vid_idx];
   assign changed  = chg_q;

   // R3: stepping write moves the pointer by one, modulo depth
   assert_ptr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_wr && !ptr_wr && ptr_byte[DATA_W-1]) |=>
      (ptr_byte[IDX_W-1:0] == IDX_W'($past(ptr_byte[IDX_W-1:0]) + 1)));
   // R3: non-stepping write leaves the pointer register alone
   assert_ptr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_wr && !ptr_wr && !ptr_byte[DATA_W-1]) |=> $stable(ptr_byte));
   // R8: change pulse only follows a data write
   assert_chg_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      changed |-> $past(dat_wr));
endmodule

// File: rtl/palette_port.sv
module palette_port #(
   parameter int NUM_CH  = 2,
   parameter int DATA_W  = 8,
   parameter int IDX_W   = 6,
   parameter bit VID_REG = 1'b1,
   localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
   localparam int ADDR_W = CH_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              legacy_mode,
   input  logic              pal_accessible,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [CH_W-1:0]   vid_ch,
   input  logic [IDX_W-1:0]  vid_idx,
   output logic [DATA_W-1:0] vid_data,
   output logic [NUM_CH-1:0] pal_changed
);
   if (DATA_W < IDX_W + 2) begin : g_bad_width
      $error("palette_port: DATA_W must leave room for flag and fill bit");
   end
   if (NUM_CH < 2 || (1 << CH_W) != NUM_CH) begin : g_bad_count
      $error("palette_port: NUM_CH must be a power of two, at least 2");
   end

   logic [NUM_CH-1:0]             ptr_wr, dat_wr;
   logic [NUM_CH-1:0][DATA_W-1:0] ptr_bytes, dat_bytes, vid_bytes;
   logic [CH_W-1:0]               rd_ch;
   logic [DATA_W-1:0]             rd_next;
   logic                          enabled;

   assign enabled = !legacy_mode;

   palette_decode #(.NUM_CH(NUM_CH)) u_decode (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (enabled),
      .wr     (bus_wr),
      .addr   (bus_addr),
      .ptr_wr (ptr_wr),
      .dat_wr (dat_wr)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      palette_channel #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_ch (
         .clk      (clk),
         .rst_n    (rst_n),
         .ptr_wr   (ptr_wr[c]),
         .dat_wr   (dat_wr[c]),
         .wdata    (bus_wdata),
         .ptr_byte (ptr_bytes[c]),
         .dat_byte (dat_bytes[c]),
         .vid_idx  (vid_idx),
         .vid_byte (vid_bytes[c]),
         .changed  (pal_changed[c])
      );
   end

   assign rd_ch = bus_addr[ADDR_W-1:1];

   always_comb begin
      if (!bus_addr[0])
         rd_next = ptr_bytes[rd_ch];
      else if (enabled && pal_accessible)
         rd_next = dat_bytes[rd_ch];
      else
         rd_next = '1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) bus_rdata <= '1;
      else if (bus_rd) bus_rdata <= rd_next;
   end

   if (VID_REG) begin : g_vid_reg
      always_ff @(posedge clk) begin
         if (!rst_n) vid_data <= '1;
         else vid_data <= vid_bytes[vid_ch];
      end
   end else begin : g_vid_comb
      assign vid_data = vid_bytes[vid_ch];
   end

   // R5: legacy-mode writes leave every pointer register as it was
   assert_legacy_ignore_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (legacy_mode && bus_wr) |=> $stable(ptr_bytes));
   // R4: gated data read yields all ones
   assert_gated_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr[0] && (legacy_mode || !pal_accessible)) |=> (bus_rdata == '1));
   // R4: reads alone never move a pointer
   assert_read_no_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !bus_wr) |=> $stable(ptr_bytes));
   // R7: read data holds between reads
   assert_rdata_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/palette_port_test.sv
`timescale 1ns/1ps
module palette_port_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       legacy_mode = 1'b0;
   logic       pal_accessible = 1'b1;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [1:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [0:0] vid_ch = '0;
   logic [5:0] vid_idx = '0;
   logic [7:0] vid_data;
   logic [1:0] pal_changed;

   int checks = 0;
   int fails  = 0;
   logic [1:0] last_chg;
   logic [7:0] got;

   always #4 clk = ~clk;

   palette_port uut (
      .clk(clk), .rst_n(rst_n), .legacy_mode(legacy_mode),
      .pal_accessible(pal_accessible), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .vid_ch(vid_ch), .vid_idx(vid_idx), .vid_data(vid_data),
      .pal_changed(pal_changed)
   );

   // fields: [24:21] req, [20] read, [19] legacy, [18] accessible,
   //         [17:16] addr, [15:8] wdata, [7:0] expected read value
   localparam int NV = 20;
   localparam logic [24:0] VEC [NV] = '{
      {4'd3, 1'b0, 1'b0, 1'b1, 2'd0, 8'h80, 8'h00}, // R3 bg pointer 0, stepping
      {4'd3, 1'b0, 1'b0, 1'b1, 2'd1, 8'h11, 8'h00}, // R3 bg[0]
      {4'd3, 1'b0, 1'b0, 1'b1, 2'd1, 8'h22, 8'h00}, // R3 bg[1]
      {4'd2, 1'b1, 1'b0, 1'b1, 2'd0, 8'h00, 8'hC2}, // R2 flag, fill 1, ptr 2
      {4'd4, 1'b1, 1'b0, 1'b1, 2'd1, 8'h00, 8'hFF}, // R4 bg[2] still reset value
      {4'd4, 1'b1, 1'b0, 1'b1, 2'd1, 8'h00, 8'hFF}, // R4 repeated read
      {4'd4, 1'b1, 1'b0, 1'b1, 2'd0, 8'h00, 8'hC2}, // R4 reads did not step
      {4'd2, 1'b0, 1'b0, 1'b1, 2'd0, 8'h00, 8'h00}, // R2 write bit6=0, ptr 0
      {4'd2, 1'b1, 1'b0, 1'b1, 2'd0, 8'h00, 8'h40}, // R2 bit 6 reads 1
      {4'd4, 1'b1, 1'b0, 1'b1, 2'd1, 8'h00, 8'h11}, // R4 bg[0]
      {4'd4, 1'b0, 1'b0, 1'b1, 2'd0, 8'h01, 8'h00}, // R4 pointer 1
      {4'd4, 1'b1, 1'b0, 1'b1, 2'd1, 8'h00, 8'h22}, // R4 bg[1]
      {4'd4, 1'b1, 1'b0, 1'b0, 2'd1, 8'h00, 8'hFF}, // R4 gate low
      {4'd3, 1'b0, 1'b0, 1'b1, 2'd2, 8'hBF, 8'h00}, // R3 obj pointer 63, stepping
      {4'd3, 1'b0, 1'b0, 1'b1, 2'd3, 8'h5A, 8'h00}, // R3 obj[63]
      {4'd3, 1'b1, 1'b0, 1'b1, 2'd2, 8'h00, 8'hC0}, // R3 wrapped to 0
      {4'd1, 1'b0, 1'b0, 1'b1, 2'd2, 8'h3F, 8'h00}, // R1 obj pointer 63 no step
      {4'd1, 1'b1, 1'b0, 1'b1, 2'd3, 8'h00, 8'h5A}, // R1 obj channel separate
      {4'd1, 1'b1, 1'b0, 1'b1, 2'd0, 8'h00, 8'h41}, // R1 bg pointer untouched
      {4'd1, 1'b1, 1'b0, 1'b1, 2'd1, 8'h00, 8'h22}  // R1 bg data untouched
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      last_chg = pal_changed;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [7:0] v);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      v = bus_rdata;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R6: reset state of both channels
      bus_read(2'd0, got); check("R6 bg pointer", got, 8'hFF);
      bus_read(2'd2, got); check("R6 obj pointer", got, 8'hFF);
      bus_read(2'd1, got); check("R6 bg data", got, 8'hFF);
      bus_read(2'd3, got); check("R6 obj data", got, 8'hFF);

      for (int i = 0; i < NV; i++) begin
         legacy_mode    = VEC[i][19];
         pal_accessible = VEC[i][18];
         if (VEC[i][20]) begin
            bus_read(VEC[i][17:16], got);
            check($sformatf("R%0d vector %0d", VEC[i][24:21], i), got, VEC[i][7:0]);
         end else begin
            bus_write(VEC[i][17:16], VEC[i][15:8]);
         end
      end
      legacy_mode = 1'b0; pal_accessible = 1'b1;

      // R7: rdata holds while no read is issued
      repeat (3) @(negedge clk);
      check("R7 hold", bus_rdata, 8'h22);

      // R5: legacy mode drops writes, pointer reads still work, data reads 0xFF
      legacy_mode = 1'b1;
      bus_write(2'd2, 8'h85);
      bus_write(2'd3, 8'h00);
      bus_read(2'd2, got); check("R5 pointer kept", got, 8'h7F);
      bus_read(2'd3, got); check("R4 legacy data read", got, 8'hFF);
      legacy_mode = 1'b0;
      bus_read(2'd3, got); check("R5 data kept", got, 8'h5A);

      // R8: same value gives no pulse, new value pulses its own channel
      bus_write(2'd3, 8'h5A);
      check("R8 same value no pulse", {6'd0, last_chg}, 8'h00);
      bus_write(2'd3, 8'h5B);
      check("R8 pulse obj only", {6'd0, last_chg}, 8'h02);
      @(negedge clk);
      check("R8 pulse one cycle", {6'd0, pal_changed}, 8'h00);

      // R8: same-value write still steps the pointer
      bus_write(2'd2, 8'h8A);
      bus_write(2'd3, 8'hFF);
      check("R8 same value, no pulse", {6'd0, last_chg}, 8'h00);
      bus_read(2'd2, got); check("R8 stepped anyway", got, 8'hCB);

      // R9: video port, independent of gate and legacy mode
      pal_accessible = 1'b0; legacy_mode = 1'b1;
      @(negedge clk); vid_ch = 1'b0; vid_idx = 6'd1;
      @(negedge clk); check("R9 bg[1]", vid_data, 8'h22);
      vid_ch = 1'b1; vid_idx = 6'd63;
      @(negedge clk); check("R9 obj[63]", vid_data, 8'h5B);
      vid_idx = 6'd10;
      @(negedge clk); check("R9 obj[10]", vid_data, 8'hFF);
      legacy_mode = 1'b0; pal_accessible = 1'b1;

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule